// File: doc/BRIEF.md
# Bus-Mapped Serial Port with Single Receive Holding Register

This block is a compact asynchronous serial port that sits on an APB slave port. It sends and receives 8-bit characters framed as one low start bit, eight data bits sent least significant first, and one high stop bit. A 16-bit divider sets how many system clocks make up one sampling tick, and every bit lasts eight ticks. Software sees three word registers. A transmit/receive data register, a divider register and a read-only status word are the three.

A bus write to the data register starts a frame when the transmitter is idle. The receiver shifts a frame in while the previously completed byte waits in a holding register. A bus read of the data register returns the held byte and clears the receive flags. If a new byte completes while the old one is still unread, the new byte replaces the old one and an overflow flag is raised. Two corner cases are handled on purpose. A bus read that coincides with a byte moving into the holding register loses neither byte. A serial input held low produces exactly one zero byte, and the receiver then waits for the line to go high again.

Top module: `apb_uart_lite`

## Requirements
- R1: After reset the status word reads 0x4, the divider register reads the DEF_DIV parameter, txd is high, and an unmapped offset (0xC) reads 0. Register offsets are 0x0 data, 0x4 divider and 0x8 status, and paddr[1:0] is ignored.
- R2: The divider register holds the value written to its low 16 bits. Each serial bit lasts 8 x divider clocks, so the byte 0x01 drives txd low for exactly 56 x divider clocks between its bit 0 and its stop bit.
- R3: A byte written to the data register is sent as start(0), 8 data bits LSB first and stop(1). Looped back to rxd, it reads back unchanged in prdata[7:0], with prdata[31:8] zero, and status bit 0 (data waiting) is set.
- R4: A completed access-phase read of the data register clears status bit 0 and status bit 1 (overflow).
- R5: When a second byte completes before the first is read, status bit 1 is set (status 0x7 when idle), and the data register returns the newer byte.
- R6: A data read whose transfer coincides with a new byte entering the holding register returns the old byte. The new byte then remains readable, with bit 0 set and bit 1 clear.
- R7: A serial input held low yields exactly one 0x00 byte with no overflow, however long it stays low. After the line returns high, the next frame is received correctly.
- R8: Status bit 2 (transmitter ready) clears on the cycle after a data write and sets again only after the stop bit. A data write while the transmitter is busy is ignored.
- R9: Writes and read side effects occur only when psel and penable are both high. A setup phase alone neither clears the receive flags nor starts a transmission.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| psel | input | 1 | APB slave select |
| penable | input | 1 | APB access phase strobe |
| pwrite | input | 1 | APB write when high, read when low |
| paddr | input | ADDR_W | APB byte address; bits [3:2] select the register |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data, registered during the setup phase |
| rxd | input | 1 | Serial receive line, asynchronous to clk |
| txd | output | 1 | Serial transmit line, idle high |

## Verification
The hardest situation to reach from the ports is a data-register read that lands on the very cycle a new byte moves into the holding register. There is no port that shows when that move happens. To reach it, the stimulus leaves one byte unread, sends a second byte over the loopback, and then starts the data read at every cycle offset across a window of about eighty cycles around the expected load time. Every offset must give one of exactly two legal outcomes: either the old byte followed by the new byte with no overflow, or the new byte with the flags cleared. Both outcomes must appear somewhere across the sweep.

// File: rtl/uart_lite_pkg.sv
package uart_lite_pkg;

  // Sampling ticks per serial bit
  localparam int TICKS_PER_BIT = 8;

  // Register indices taken from paddr[3:2]
  localparam int IDX_DATA = 0;
  localparam int IDX_DIV  = 1;
  localparam int IDX_STAT = 2;

  // Receiver states; LOAD is the one-cycle transfer into the holding register
  typedef enum logic [1:0] {
    RX_IDLE  = 2'b00,
    RX_SHIFT = 2'b01,
    RX_LOAD  = 2'b10,
    RX_STOP  = 2'b11
  } rx_state_t;

endpackage

// File: rtl/uart_lite_tick.sv
module uart_lite_tick #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q;

  // Free-running down counter: one tick every max(div,1) clocks
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      tick  <= 1'b0;
    end else begin
      tick <= (cnt_q == '0);
      if (cnt_q == '0)
        cnt_q <= (div == '0) ? '0 : div - 1'b1;
      else
        cnt_q <= cnt_q - 1'b1;
    end
  end

endmodule

// File: rtl/uart_lite_tx.sv
module uart_lite_tx #(
  parameter int DATA_W = 8,
  parameter int TICKS  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              start,
  input  logic [DATA_W-1:0] data,
  output logic              txd,
  output logic              ready
);

  localparam int CNT_W = $clog2(TICKS);
  localparam int BIT_W = $clog2(DATA_W + 2);

  logic              busy_q;
  logic [CNT_W-1:0]  tcnt_q;
  logic [BIT_W-1:0]  bitn_q;
  logic [DATA_W:0]   frame_q;   // data bits then stop bit

  assign ready = !busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      tcnt_q  <= '0;
      bitn_q  <= '0;
      frame_q <= '1;
      txd     <= 1'b1;
    end else if (!busy_q) begin
      txd <= 1'b1;
      if (start) begin
        busy_q  <= 1'b1;
        tcnt_q  <= '0;
        bitn_q  <= '0;
        frame_q <= {1'b1, data};
        txd     <= 1'b0;          // start bit
      end
    end else if (tick) begin
      if (tcnt_q == CNT_W'(TICKS - 1)) begin
        tcnt_q <= '0;
        if (bitn_q == BIT_W'(DATA_W + 1)) begin
          busy_q <= 1'b0;         // stop bit fully driven
          txd    <= 1'b1;
        end else begin
          txd     <= frame_q[0];
          frame_q <= {1'b1, frame_q[DATA_W:1]};
          bitn_q  <= bitn_q + 1'b1;
        end
      end else begin
        tcnt_q <= tcnt_q + 1'b1;
      end
    end
  end

  AST_READY_DROP: assert property (@(posedge clk) disable iff (rst)
    (start && ready) |=> !ready); // R8
  AST_TXD_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
    (ready && $past(ready)) |-> txd); // R3

endmodule

// File: rtl/uart_lite_rx.sv
module uart_lite_rx
  import uart_lite_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int TICKS  = 8,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              rxd,
  output logic              load,
  output logic [DATA_W-1:0] data
);

  localparam int CNT_W = $clog2(TICKS);
  localparam int BIT_W = $clog2(DATA_W);

  logic [SYNC_N-1:0] sync_q;
  logic              rx_s;
  rx_state_t         state_q;
  logic [CNT_W-1:0]  tcnt_q;
  logic [BIT_W-1:0]  bitn_q;
  logic [DATA_W-1:0] shreg_q;

  // Input synchronizer, reset to the idle level
  always_ff @(posedge clk) begin
    if (rst) sync_q <= '1;
    else     sync_q <= {sync_q[SYNC_N-2:0], rxd};
  end
  assign rx_s = sync_q[SYNC_N-1];

  assign load = (state_q == RX_LOAD);
  assign data = shreg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= RX_IDLE;
      tcnt_q  <= '0;
      bitn_q  <= '0;
      shreg_q <= '0;
    end else begin
      case (state_q)
        RX_IDLE: if (tick) begin
          if (rx_s) begin
            tcnt_q <= '0;
          end else if (tcnt_q == CNT_W'(TICKS/2 - 1)) begin
            state_q <= RX_SHIFT;   // start bit confirmed at mid-bit
            tcnt_q  <= '0;
            bitn_q  <= '0;
          end else begin
            tcnt_q <= tcnt_q + 1'b1;
          end
        end
        RX_SHIFT: if (tick) begin
          if (tcnt_q == CNT_W'(TICKS - 1)) begin
            tcnt_q  <= '0;
            shreg_q <= {rx_s, shreg_q[DATA_W-1:1]};
            if (bitn_q == BIT_W'(DATA_W - 1)) state_q <= RX_LOAD;
            else                              bitn_q  <= bitn_q + 1'b1;
          end else begin
            tcnt_q <= tcnt_q + 1'b1;
          end
        end
        RX_LOAD: state_q <= RX_STOP;
        RX_STOP: if (tick && rx_s) begin
          state_q <= RX_IDLE;      // line back at idle level
          tcnt_q  <= '0;
        end
        default: state_q <= RX_IDLE;
      endcase
    end
  end

  AST_STOP_WAITS_HIGH: assert property (@(posedge clk) disable iff (rst)
    (state_q == RX_STOP && !rx_s) |=> (state_q == RX_STOP)); // R7
  AST_SINGLE_LOAD: assert property (@(posedge clk) disable iff (rst)
    load |=> !load); // R7

endmodule

// File: rtl/apb_uart_lite.sv
module apb_uart_lite
  import uart_lite_pkg::*;
#(
  parameter int          ADDR_W  = 4,
  parameter int          BUS_W   = 32,
  parameter int          DATA_W  = 8,
  parameter int          DIV_W   = 16,
  parameter int          SYNC_N  = 2,
  parameter logic [15:0] DEF_DIV = 16'd27
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [BUS_W-1:0]  pwdata,
  output logic [BUS_W-1:0]  prdata,
  input  logic              rxd,
  output logic              txd
);

  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0]  idx;
  logic              setup_ph, wr_acc, rd_acc;
  logic              tx_start, rd_clear;
  logic              tick, tx_ready, rx_load;
  logic [DATA_W-1:0] rx_data;
  logic [DIV_W-1:0]  div_q;
  logic [DATA_W-1:0] hold_q;
  logic              rx_valid, rx_ovf, setup_load_q;
  logic              unused_bits;

  assign idx      = paddr[ADDR_W-1:2];
  assign setup_ph = psel && !penable;
  assign wr_acc   = psel && penable && pwrite;
  assign rd_acc   = psel && penable && !pwrite;
  assign tx_start = wr_acc && (idx == IDX_W'(IDX_DATA)) && tx_ready;
  assign rd_clear = rd_acc && (idx == IDX_W'(IDX_DATA));
  assign unused_bits = ^{paddr[1:0], pwdata[BUS_W-1:DIV_W]};

  uart_lite_tick #(.DIV_W(DIV_W)) u_tick (
    .clk (clk), .rst (rst), .div (div_q), .tick (tick)
  );

  uart_lite_tx #(.DATA_W(DATA_W), .TICKS(TICKS_PER_BIT)) u_tx (
    .clk (clk), .rst (rst), .tick (tick), .start (tx_start),
    .data (pwdata[DATA_W-1:0]), .txd (txd), .ready (tx_ready)
  );

  uart_lite_rx #(.DATA_W(DATA_W), .TICKS(TICKS_PER_BIT), .SYNC_N(SYNC_N)) u_rx (
    .clk (clk), .rst (rst), .tick (tick), .rxd (rxd),
    .load (rx_load), .data (rx_data)
  );

  // Divider register
  always_ff @(posedge clk) begin
    if (rst)                                      div_q <= DIV_W'(DEF_DIV);
    else if (wr_acc && idx == IDX_W'(IDX_DIV))    div_q <= pwdata[DIV_W-1:0];
  end

  // Read data is captured in the setup phase so it is a register in access
  always_ff @(posedge clk) begin
    if (rst) begin
      prdata       <= '0;
      setup_load_q <= 1'b0;
    end else if (setup_ph) begin
      setup_load_q <= rx_load;
      if (pwrite) prdata <= prdata;
      else begin
        case (idx)
          IDX_W'(IDX_DATA): prdata <= BUS_W'(hold_q);
          IDX_W'(IDX_DIV):  prdata <= BUS_W'(div_q);
          IDX_W'(IDX_STAT): prdata <= BUS_W'({tx_ready, rx_ovf, rx_valid});
          default:          prdata <= '0;
        endcase
      end
    end
  end

  // Holding register and receive flags
  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q   <= '0;
      rx_valid <= 1'b0;
      rx_ovf   <= 1'b0;
    end else if (rx_load) begin
      hold_q   <= rx_data;
      rx_valid <= 1'b1;
      // A read finishing now has taken the old byte: no overflow
      rx_ovf   <= rd_clear ? 1'b0 : rx_valid;
    end else if (rd_clear) begin
      // A byte loaded at this read's setup edge was not delivered: keep it
      rx_valid <= setup_load_q;
      rx_ovf   <= 1'b0;
    end
  end

  AST_OVF_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    rx_ovf |-> rx_valid); // R5
  AST_NO_LOST_BYTE: assert property (@(posedge clk) disable iff (rst)
    (rx_load && rd_clear) |=> (rx_valid && !rx_ovf)); // R6
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (rd_clear && !rx_load && !setup_load_q) |=> (!rx_valid && !rx_ovf)); // R4
  AST_SETUP_NO_EFFECT: assert property (@(posedge clk) disable iff (rst)
    (!(psel && penable) && !rx_load) |=> ($stable(rx_valid) && $stable(div_q))); // R9

endmodule

// File: tb/apb_uart_lite_bench.sv
`timescale 1ns/1ps
module apb_uart_lite_bench;

  localparam logic [15:0] DEF_DIV = 16'd27;
  localparam logic [3:0]  A_DATA = 4'h0, A_DIV = 4'h4, A_STAT = 4'h8, A_NONE = 4'hC;

  // {divider, byte} vectors walked by the table loop
  localparam logic [23:0] VEC [6] = '{24'h0002_81, 24'h0002_7E, 24'h0003_FF,
                                      24'h0001_00, 24'h0005_C3, 24'h0002_5A};

  logic clk = 1'b0, rst = 1'b1;
  logic psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [3:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic txd, rxd, force_low = 1'b0;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  assign rxd = force_low ? 1'b0 : txd;   // loopback

  always #4 clk = ~clk;                  // 125 MHz

  apb_uart_lite #(.DEF_DIV(DEF_DIV)) u_apb_uart_lite (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .rxd(rxd), .txd(txd)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic apb_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apb_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(negedge clk); penable = 1;
    @(negedge clk); d = prdata; psel = 0; penable = 0;
  endtask

  task automatic wait_ready();
    logic [31:0] s;
    s = '0;
    for (int i = 0; i < 3000 && !s[2]; i++) apb_read(A_STAT, s);
  endtask

  task automatic drain();
    logic [31:0] s, d;
    apb_read(A_STAT, s);
    if (s[0]) apb_read(A_DATA, d);
  endtask

  initial begin
    logic [31:0] r, s, r2;
    int lowcnt, n_old, n_new;
    cyc(4); rst = 0; cyc(2);

    // R1: reset state
    chk("R1 txd idle", {31'b0, txd}, 32'h1);
    apb_read(A_STAT, r); chk("R1 status", r, 32'h4);
    apb_read(A_DIV, r);  chk("R1 divider default", r, {16'b0, DEF_DIV});
    apb_read(A_NONE, r); chk("R1 unmapped", r, 32'h0);

    // R3/R4 table walk
    for (int i = 0; i < 6; i++) begin
      apb_write(A_DIV, {16'b0, VEC[i][23:8]});
      apb_read(A_DIV, r); chk("R2 divider readback", r, {16'b0, VEC[i][23:8]});
      apb_write(A_DATA, {24'hFFFFFF, VEC[i][7:0]});
      cyc(96 * int'(VEC[i][23:8]) + 40);
      apb_read(A_STAT, r); chk("R3 status after rx", r, 32'h5);
      apb_read(A_DATA, r); chk("R3 loopback byte", r, {24'b0, VEC[i][7:0]});
      apb_read(A_STAT, r); chk("R4 flags cleared", r, 32'h4);
    end

    // R2: bit period from a low run of 7 bits
    apb_write(A_DIV, 32'd3);
    apb_write(A_DATA, 32'h01);
    while (txd !== 1'b1) @(negedge clk);
    while (txd !== 1'b0) @(negedge clk);
    lowcnt = 0;
    while (txd === 1'b0) begin lowcnt++; @(negedge clk); end
    chk("R2 seven-bit low run", lowcnt, 32'd168);
    cyc(200); drain();

    // R8: ready drop, busy write ignored
    apb_write(A_DIV, 32'd2);
    apb_write(A_DATA, 32'h3C);
    apb_read(A_STAT, r); chk("R8 ready low after write", r & 32'h4, 32'h0);
    apb_write(A_DATA, 32'hC3);
    wait_ready(); cyc(40);
    apb_read(A_STAT, r); chk("R8 only one byte, no overflow", r, 32'h5);
    apb_read(A_DATA, r); chk("R8 first byte kept", r, 32'h3C);

    // R9: setup phase only has no side effect
    apb_write(A_DATA, 32'h77); wait_ready(); cyc(40);
    @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = A_DATA;
    @(negedge clk); psel = 0;
    @(negedge clk); psel = 1; pwrite = 1; pwdata = 32'h11;
    @(negedge clk); psel = 0; pwrite = 0;
    apb_read(A_STAT, r); chk("R9 setup-only leaves flags and tx", r, 32'h5);
    apb_read(A_DATA, r); chk("R9 byte still held", r, 32'h77);

    // R5: overflow keeps newest byte
    apb_write(A_DATA, 32'hA1); wait_ready();
    apb_write(A_DATA, 32'h5E); wait_ready(); cyc(40);
    apb_read(A_STAT, r); chk("R5 overflow status", r, 32'h7);
    apb_read(A_DATA, r); chk("R5 newest byte", r, 32'h5E);
    apb_read(A_STAT, r); chk("R4 overflow cleared by read", r, 32'h4);

    // R7: line stuck low
    force_low = 1; cyc(12 * 16);
    apb_read(A_STAT, r); chk("R7 one zero byte", r, 32'h5);
    cyc(20 * 16);
    apb_read(A_STAT, r); chk("R7 still no overflow", r, 32'h5);
    apb_read(A_DATA, r); chk("R7 byte is zero", r, 32'h0);
    force_low = 0; cyc(3 * 16);
    apb_write(A_DATA, 32'hA5); wait_ready(); cyc(40);
    apb_read(A_STAT, r); chk("R7 receive after release", r, 32'h5);
    apb_read(A_DATA, r); chk("R7 byte after release", r, 32'hA5);

    // R6: sweep the data read across the load of a second byte
    n_old = 0; n_new = 0;
    for (int off = 100; off <= 180; off++) begin
      drain();
      apb_write(A_DATA, 32'h69); wait_ready();
      apb_write(A_DATA, 32'h96);
      cyc(off);
      apb_read(A_DATA, r);
      cyc(12 * 16 + 30);
      apb_read(A_STAT, s);
      if (r == 32'h69) begin
        n_old++;
        chk("R6 new byte kept without overflow", s, 32'h5);
        apb_read(A_DATA, r2); chk("R6 new byte value", r2, 32'h96);
      end else begin
        n_new++;
        chk("R6 late read gets new byte", r, 32'h96);
        chk("R6 late read clears flags", s, 32'h4);
      end
    end
    chk("R6 sweep covers both sides", {30'b0, n_old > 0, n_new > 0}, 32'h3);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule